// File: doc/BRIEF.md
# Timer Clock Prescaler with Synchronized Hold

This block is the clock front end for an 8-bit timer/counter. It produces a single-cycle count-enable strobe, `cnt_en`, that the timer core uses to advance. A 3-bit clock-select input picks the strobe's source. The source can be one of four taps of a free-running 10-bit prescaler, the undivided system clock, an external pin on either edge, or nothing at all.

An external pin signal passes through a two-flop synchronizer and an edge detector. It never goes through the prescaler.

A one-byte control register is written through a plain write strobe and read back combinationally. It holds two bits:

- **Bit 0, restart bit.** Writing one to it restarts the prescaler. The bit normally clears itself.
- **Bit 7, hold-mode bit.** While this bit is one, the restart bit keeps whatever value was written to it. A held restart bit keeps the prescaler in reset and blocks every strobe. Software can then reconfigure the timer without it advancing. Writing zero to bit 7 clears the restart bit, and counting resumes from a fresh prescaler phase.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_prescale_front`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00.
- R2: A write with bit 0 set and bit 7 clear restarts the prescaler. The following cycle starts a new phase at count zero. `cnt_en` is low in the write cycle even with `clk_sel`=1. Bit 0 then reads back 0.
- R3: A write with bits 7 and 0 both set reads back 0x81. While that value is held, `cnt_en` stays low for every `clk_sel` code, including external edges.
- R4: Writing 0x00 while the hold is in effect clears bit 0. For a divide-by-N setting, the first strobe appears in the N-th cycle after the write cycle, and strobes then follow every N cycles.
- R5: Bits 6 to 1 always read zero and ignore writes. Writing 0x7E reads back 0x00 and leaves counting running. Writing 0xFF reads back 0x81.
- R6: `clk_sel`=1 gives `cnt_en` high in every cycle when not held.
- R7: `clk_sel` codes 2, 3, 4 and 5 give one strobe every 8, 64, 256 and 1024 cycles respectively.
- R8: `clk_sel`=0 gives no strobes.
- R9: `clk_sel`=7 gives one strobe per rising edge of `ext_pin`. `clk_sel`=6 gives one strobe per falling edge. The strobe lasts one cycle and is visible in the cycle after the second clock edge that samples the new pin level. The opposite edge gives nothing.
- R10: Writing 0x80 (hold mode with bit 0 zero) reads back 0x80 and does not stop counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| clk_sel | input | 3 | Strobe source: 0 off, 1 /1, 2 /8, 3 /64, 4 /256, 5 /1024, 6 pin falling, 7 pin rising |
| ext_pin | input | 1 | Asynchronous external count input |
| cnt_en | output | 1 | One-cycle count-enable strobe for the timer |

## Verification
Two events can land in the same cycle: a restart write and a strobe that a tap would otherwise emit. The bench provokes this with `clk_sel`=1, where a strobe is due in every cycle. It samples `cnt_en` during the write cycle itself and expects it low.

The bench also checks that a hold does not swallow the prescaler phase. When the hold is released under a divide-by-8 setting, it expects the first strobe exactly eight cycles after the releasing write. It likewise toggles the external pin while the hold is in effect and expects no strobe from those edges.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam int NTAPS = 5;
  // log2 of each divider tap, ordered like the clock-select codes 1..5
  localparam int TAP_LOG2 [NTAPS] = '{0, 3, 6, 8, 10};

  localparam int REG_W   = 8;
  localparam int HOLD_BIT = 7;
  localparam int RST_BIT  = 0;
endpackage

// File: rtl/tps_ctrl_reg.sv
module tps_ctrl_reg
  import tps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             presc_clr
);
  logic hold_mode_q;
  logic restart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_mode_q <= 1'b0;
      restart_q   <= 1'b0;
    end else if (wr_en) begin
      hold_mode_q <= wr_data[HOLD_BIT];
      // restart bit only persists while hold mode is written as one
      restart_q   <= wr_data[HOLD_BIT] & wr_data[RST_BIT];
    end else if (!hold_mode_q) begin
      restart_q   <= 1'b0;
    end
  end

  assign presc_clr = restart_q | (wr_en & wr_data[RST_BIT]);

  always_comb begin
    rd_data           = '0;
    rd_data[HOLD_BIT] = hold_mode_q;
    rd_data[RST_BIT]  = restart_q;
  end

  // R4
  hold_release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_mode_q) |-> !restart_q);

  // R3
  sticky_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> hold_mode_q);
endmodule

// File: rtl/tps_divider.sv
module tps_divider
  import tps_pkg::*;
#(
  parameter int PRESC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [NTAPS-1:0] tap_hit
);
  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    localparam logic [PRESC_W-1:0] MASK = PRESC_W'((1 << TAP_LOG2[i]) - 1);
    assign tap_hit[i] = &(cnt_q | ~MASK);
    if (i > 0) begin : g_nest
      // R7
      tap_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_hit[i] |-> tap_hit[i-1]);
    end
  end
endmodule

// File: rtl/tps_edge_det.sv
module tps_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr_prescale_front.sv
module tmr_prescale_front
  import tps_pkg::*;
#(
  parameter int PRESC_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [2:0] clk_sel,
  input  logic       ext_pin,
  output logic       cnt_en
);
  logic             presc_clr;
  logic [NTAPS-1:0] tap_hit;
  logic             ext_rise, ext_fall;
  logic             src_hit;
  clk_sel_e         sel;

  tps_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .presc_clr(presc_clr)
  );

  tps_divider #(.PRESC_W(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(presc_clr), .tap_hit(tap_hit)
  );

  tps_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise), .fall(ext_fall)
  );

  assign sel = clk_sel_e'(clk_sel);

  always_comb begin
    unique case (sel)
      CS_OFF:      src_hit = 1'b0;
      CS_DIV1:     src_hit = tap_hit[0];
      CS_DIV8:     src_hit = tap_hit[1];
      CS_DIV64:    src_hit = tap_hit[2];
      CS_DIV256:   src_hit = tap_hit[3];
      CS_DIV1024:  src_hit = tap_hit[4];
      CS_EXT_FALL: src_hit = ext_fall;
      CS_EXT_RISE: src_hit = ext_rise;
      default:     src_hit = 1'b0;
    endcase
  end

  assign cnt_en = src_hit & ~presc_clr;

  // R3
  hold_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |-> !cnt_en);

  // R8
  off_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> !cnt_en);
endmodule

// File: tb/tmr_prescale_front_tb.sv
module tmr_prescale_front_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] clk_sel = 3'd0;
  logic       ext_pin = 1'b0;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;

  tmr_prescale_front u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clk_sel(clk_sel), .ext_pin(ext_pin), .cnt_en(cnt_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write in the current cycle; returns at the negedge of the following cycle
  task automatic reg_write(logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // sample w cycles starting in the current one; first = 1-based index of first strobe
  task automatic watch(int w, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= w; i++) begin
      #1;
      if (cnt_en) begin
        cnt++;
        if (first == 0) first = i;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 readback", reg_rdata, 8'h00);
  endtask

  task automatic t_div1;
    int c, f;
    clk_sel = 3'd1;
    watch(20, c, f);
    check("R6 div1 count", c, 20);
  endtask

  task automatic t_restart_collision;
    int c, f;
    clk_sel = 3'd1;
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h01;
    #1;
    check("R2 strobe in write cycle", cnt_en, 0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    check("R2 bit0 self clears", reg_rdata, 8'h00);
    clk_sel = 3'd2;
    reg_write(8'h01);
    watch(24, c, f);
    check("R2 first div8 strobe", f, 8);
    check("R2 div8 count", c, 3);
  endtask

  task automatic t_dividers;
    int c, f;
    int codes [4] = '{2, 3, 4, 5};
    int divs  [4] = '{8, 64, 256, 1024};
    for (int k = 0; k < 4; k++) begin
      clk_sel = codes[k][2:0];
      reg_write(8'h01);
      watch(3*divs[k], c, f);
      check($sformatf("R7 div%0d first", divs[k]), f, divs[k]);
      check($sformatf("R7 div%0d count", divs[k]), c, 3);
    end
  endtask

  task automatic t_off;
    int c, f;
    clk_sel = 3'd0;
    watch(40, c, f);
    check("R8 off count", c, 0);
  endtask

  task automatic ext_step(logic lvl, output int c);
    int f;
    @(negedge clk);
    ext_pin = lvl;
    @(negedge clk);
    watch(6, c, f);
  endtask

  task automatic t_ext;
    int c, f;
    clk_sel = 3'd7;
    @(negedge clk);
    ext_pin = 1'b1;
    #1; check("R9 no strobe before sync", cnt_en, 0);
    @(negedge clk); #1; check("R9 no strobe after 1 edge", cnt_en, 0);
    @(negedge clk); #1; check("R9 rise strobe after 2 edges", cnt_en, 1);
    @(negedge clk); #1; check("R9 rise one cycle", cnt_en, 0);
    ext_step(1'b0, c);
    check("R9 rise sel ignores fall", c, 0);
    clk_sel = 3'd6;
    ext_step(1'b1, c);
    check("R9 fall sel ignores rise", c, 0);
    ext_step(1'b0, c);
    check("R9 fall count", c, 1);
    for (int i = 0; i < 3; i++) begin
      ext_step(1'b1, c); ext_step(1'b0, c);
      check("R9 fall per toggle", c, 1);
    end
  endtask

  task automatic t_hold;
    int c, f;
    clk_sel = 3'd1;
    reg_write(8'h81);
    #1; check("R3 readback held", reg_rdata, 8'h81);
    for (int s = 0; s < 8; s++) begin
      clk_sel = s[2:0];
      watch(30, c, f);
      check($sformatf("R3 held sel%0d", s), c, 0);
    end
    clk_sel = 3'd7;
    ext_step(1'b1, c);
    check("R3 held ext edge", c, 0);
    ext_step(1'b0, c);
    clk_sel = 3'd2;
    reg_write(8'h00);
    #1; check("R4 readback released", reg_rdata, 8'h00);
    watch(24, c, f);
    check("R4 first div8 after release", f, 8);
    check("R4 div8 count after release", c, 3);
  endtask

  task automatic t_reserved;
    int c, f;
    clk_sel = 3'd1;
    reg_write(8'h7E);
    #1; check("R5 reserved read zero", reg_rdata, 8'h00);
    watch(10, c, f);
    check("R5 counting unaffected", c, 10);
    reg_write(8'hFF);
    #1; check("R5 all ones readback", reg_rdata, 8'h81);
    reg_write(8'h00);
  endtask

  task automatic t_mode_only;
    int c, f;
    clk_sel = 3'd1;
    reg_write(8'h80);
    #1; check("R10 readback", reg_rdata, 8'h80);
    watch(12, c, f);
    check("R10 still counting", c, 12);
    reg_write(8'h00);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_div1();
    t_restart_collision();
    t_dividers();
    t_off();
    t_ext();
    t_hold();
    t_reserved();
    t_mode_only();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule